// File: doc/BRIEF.md
# Segmented dual-DAC code splitter

This block splits one offset-binary audio sample into two 16-bit words for a pair of identical current-output DAC channels. The currents of the two channels are summed outside the chip. The two channels act as a lower segment and an upper segment of one wider converter.

The most significant input bit never reaches either DAC. It chooses which segment carries the signal. When that bit is clear, the upper word rests at all zeros and the lower word carries the remaining bits. When it is set, the lower word rests at all ones and the upper word carries the remaining bits plus one LSB. The sum is clamped at all ones, so the increment cannot wrap.

A mode input selects between a 17-bit sample and a 16-bit sample. In the 16-bit case the fifteen data bits are moved up one place and the LSB is written as zero. Both output words are registered together and come with a one-cycle valid pulse.

Top module: `seg_dac_splitter`

## Requirements
- R1: With `mode_wide` = 1, bit 16 of `in_sample` is the segment selector. Bits 15:0 are the payload and reach the active word unchanged, apart from the R3 correction.
- R2: When the selector is 0, `upper_word` is 0x0000 and `lower_word` equals the payload.
- R3: When the selector is 1, `lower_word` is 0xFFFF and `upper_word` equals the payload plus one.
- R4: The bipolar-zero code 0x10000 in wide mode gives `upper_word` = 0x0001 and `lower_word` = 0xFFFF.
- R5: When the payload is 0xFFFF and the selector is 1, `upper_word` saturates at 0xFFFF instead of wrapping to zero.
- R6: With `mode_wide` = 0, bit 16 of `in_sample` is ignored and bit 15 is the selector. The payload is bits 14:0 shifted left by one with bit 0 forced to 0. R2 and R3 then apply to that payload.
- R7: Negative full scale (0x00000 in wide mode) gives 0x0000 on both words.
- R8: `out_valid` is high for exactly the cycles that follow a cycle with `in_valid` high. The two words update on that same edge.
- R9: In a cycle with `in_valid` low, both words keep their previous values.
- R10: A synchronous active-high `rst` sets `upper_word` = 0x0001, `lower_word` = 0xFFFF and `out_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 17 | Offset-binary sample; in 16-bit mode only bits 15:0 are used |
| mode_wide | input | 1 | 1 = 17-bit sample, 0 = 16-bit sample |
| out_valid | output | 1 | One-cycle pulse with new words |
| upper_word | output | 16 | Word for the upper-segment DAC |
| lower_word | output | 16 | Word for the lower-segment DAC |

## Verification
The segment switch and the one-LSB correction meet in the same cycle at bipolar zero. In that cycle the upper word leaves its zero rail and takes payload+1, while the lower word jumps to its ones rail. The saturation clamp and the segment choice likewise meet at positive full scale.

The bench provokes both cases with back-to-back samples that straddle bipolar zero and full scale, in both modes. It also changes the mode on the same cycle as a valid sample. A behavioural model predicts both words and the valid pulse for every clock, and the bench compares them with the outputs one cycle after each edge.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  typedef enum logic {
    SEG_LOWER = 1'b0,
    SEG_UPPER = 1'b1
  } seg_e;
endpackage

// File: rtl/sdac_field_extract.sv
module sdac_field_extract
  import sdac_pkg::*;
#(
  parameter int DAC_W = 16
) (
  input  logic [DAC_W:0]   sample,
  input  logic             wide,
  output seg_e             seg,
  output logic [DAC_W-1:0] payload
);
  localparam int NARROW_TOP = DAC_W - 1;

  logic [DAC_W-1:0] narrow_payload;

  // 16-bit mode: data bits move up one place, LSB is zero
  assign narrow_payload = {sample[NARROW_TOP-1:0], 1'b0};

  always_comb begin
    if (wide) begin
      seg     = seg_e'(sample[DAC_W]);
      payload = sample[DAC_W-1:0];
    end else begin
      seg     = seg_e'(sample[NARROW_TOP]);
      payload = narrow_payload;
    end
  end
endmodule

// File: rtl/sdac_upper_inc.sv
module sdac_upper_inc #(
  parameter int DAC_W = 16
) (
  input  logic [DAC_W-1:0] payload,
  output logic [DAC_W-1:0] corrected
);
  logic [DAC_W:0] sum;

  assign sum = {1'b0, payload} + {{DAC_W{1'b0}}, 1'b1};

  // clamp instead of wrapping at full scale
  assign corrected = sum[DAC_W] ? {DAC_W{1'b1}} : sum[DAC_W-1:0];
endmodule

// File: rtl/sdac_out_reg.sv
module sdac_out_reg #(
  parameter int DAC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DAC_W-1:0] nxt_upper,
  input  logic [DAC_W-1:0] nxt_lower,
  output logic             valid_q,
  output logic [DAC_W-1:0] upper_q,
  output logic [DAC_W-1:0] lower_q
);
  localparam logic [DAC_W-1:0] RST_UPPER = DAC_W'(1);
  localparam logic [DAC_W-1:0] RST_LOWER = {DAC_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      upper_q <= RST_UPPER;
      lower_q <= RST_LOWER;
    end else begin
      valid_q <= load;
      if (load) begin
        upper_q <= nxt_upper;
        lower_q <= nxt_lower;
      end
    end
  end
endmodule

// File: rtl/seg_dac_splitter.sv
module seg_dac_splitter
  import sdac_pkg::*;
#(
  parameter int DAC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [DAC_W:0]   in_sample,
  input  logic             mode_wide,
  output logic             out_valid,
  output logic [DAC_W-1:0] upper_word,
  output logic [DAC_W-1:0] lower_word
);
  localparam logic [DAC_W-1:0] RAIL_LO = {DAC_W{1'b0}};
  localparam logic [DAC_W-1:0] RAIL_HI = {DAC_W{1'b1}};

  seg_e             seg;
  logic [DAC_W-1:0] payload;
  logic [DAC_W-1:0] payload_inc;
  logic [DAC_W-1:0] nxt_upper;
  logic [DAC_W-1:0] nxt_lower;

  sdac_field_extract #(.DAC_W(DAC_W)) u_extract (
    .sample  (in_sample),
    .wide    (mode_wide),
    .seg     (seg),
    .payload (payload)
  );

  sdac_upper_inc #(.DAC_W(DAC_W)) u_inc (
    .payload   (payload),
    .corrected (payload_inc)
  );

  always_comb begin
    if (seg == SEG_UPPER) begin
      nxt_upper = payload_inc;
      nxt_lower = RAIL_HI;
    end else begin
      nxt_upper = RAIL_LO;
      nxt_lower = payload;
    end
  end

  sdac_out_reg #(.DAC_W(DAC_W)) u_oreg (
    .clk       (clk),
    .rst       (rst),
    .load      (in_valid),
    .nxt_upper (nxt_upper),
    .nxt_lower (nxt_lower),
    .valid_q   (out_valid),
    .upper_q   (upper_word),
    .lower_q   (lower_word)
  );
endmodule

// File: rtl/sdac_checker.sv
module sdac_checker #(
  parameter int DAC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [DAC_W:0]   in_sample,
  input logic             mode_wide,
  input logic             out_valid,
  input logic [DAC_W-1:0] upper_word,
  input logic [DAC_W-1:0] lower_word
);
  localparam logic [DAC_W-1:0] ONES = {DAC_W{1'b1}};

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R8

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R8

  AST_LOWER_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_wide && !in_sample[DAC_W]) |=>
      (upper_word == '0 && lower_word == $past(in_sample[DAC_W-1:0]))); // R2

  AST_UPPER_RAIL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_wide && in_sample[DAC_W]) |=> (lower_word == ONES)); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_wide && in_sample == {(DAC_W+1){1'b1}}) |=>
      (upper_word == ONES)); // R5

  AST_NARROW_LSB: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode_wide && !in_sample[DAC_W-1]) |=>
      (lower_word[0] == 1'b0 && upper_word == '0)); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(upper_word) && $stable(lower_word))); // R9
endmodule

bind seg_dac_splitter sdac_checker #(.DAC_W(DAC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_sample  (in_sample),
  .mode_wide  (mode_wide),
  .out_valid  (out_valid),
  .upper_word (upper_word),
  .lower_word (lower_word)
);

// File: tb/seg_dac_splitter_bench.sv
`timescale 1ns/1ps
module seg_dac_splitter_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W:0]   in_sample = '0;
  logic         mode_wide = 1'b1;
  logic         out_valid;
  logic [W-1:0] upper_word;
  logic [W-1:0] lower_word;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  int    exp_up = 1;
  int    exp_lo = 65535;
  bit    exp_v = 0;
  string exp_tag = "R10";
  string next_tag = "R1";

  always #2.5 clk = ~clk;

  seg_dac_splitter #(.DAC_W(W)) u_seg_dac_splitter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .mode_wide(mode_wide), .out_valid(out_valid),
    .upper_word(upper_word), .lower_word(lower_word)
  );

  // behavioural reference, integers only
  always @(posedge clk) begin
    int v, sel, data;
    if (rst) begin
      exp_up <= 1; exp_lo <= 65535; exp_v <= 0; exp_tag <= "R10";
    end else if (in_valid) begin
      v = int'(in_sample);
      if (mode_wide) begin
        sel = v / 65536; data = v % 65536;
      end else begin
        sel = (v / 32768) % 2; data = (v % 32768) * 2;
      end
      if (sel == 1) begin
        exp_lo <= 65535;
        exp_up <= (data + 1 > 65535) ? 65535 : data + 1;
      end else begin
        exp_lo <= data; exp_up <= 0;
      end
      exp_v <= 1; exp_tag <= next_tag;
    end else begin
      exp_v <= 0; exp_tag <= "R9";
    end
  end

  task automatic check_outs();
    n_cmp += 3;
    if (int'(upper_word) != exp_up) begin
      n_bad++;
      $display("FAIL %s upper_word actual=%h expected=%h", exp_tag, upper_word, exp_up);
    end
    if (int'(lower_word) != exp_lo) begin
      n_bad++;
      $display("FAIL %s lower_word actual=%h expected=%h", exp_tag, lower_word, exp_lo);
    end
    if (out_valid !== exp_v) begin
      n_bad++;
      $display("FAIL R8 out_valid actual=%b expected=%b (%s)", out_valid, exp_v, exp_tag);
    end
  endtask

  task automatic drive(input bit v, input int s, input bit m, input string t);
    @(negedge clk);
    check_outs();
    in_valid  = v;
    in_sample = (W+1)'(s);
    mode_wide = m;
    next_tag  = t;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check_outs(); // R10 reset state
    rst = 1'b0;
    // wide mode
    drive(1, 'h01234, 1, "R2");
    drive(1, 'h11234, 1, "R3");
    drive(1, 'h10000, 1, "R4");
    drive(1, 'h0FFFF, 1, "R1");
    drive(1, 'h10000, 1, "R4");
    drive(1, 'h1FFFF, 1, "R5");
    drive(1, 'h1FFFE, 1, "R5");
    drive(1, 'h00000, 1, "R7");
    drive(1, 'h18000, 1, "R1");
    // idle with changing inputs
    drive(0, 'h1ABCD, 1, "R9");
    drive(0, 'h05555, 0, "R9");
    // narrow mode, mode switch on a valid cycle
    drive(1, 'h08000, 0, "R6");
    drive(1, 'h0FFFF, 0, "R6");
    drive(1, 'h17FFF, 0, "R6");
    drive(1, 'h10000, 0, "R6");
    drive(1, 'h07FFF, 1, "R2");
    drive(1, 'h00001, 0, "R6");
    // reset in the middle of traffic
    drive(1, 'h1C000, 1, "R3");
    @(negedge clk); check_outs(); rst = 1'b1; in_valid = 1'b1;
    @(negedge clk); check_outs(); rst = 1'b0; in_valid = 1'b0;
    for (int i = 0; i < 400; i++) begin
      drive(bit'($urandom_range(0, 3) != 0), int'($urandom_range(0, 131071)),
            bit'($urandom_range(0, 1)), "R3");
    end
    drive(0, 0, 1, "R9");
    drive(0, 0, 1, "R9");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule